// File: doc/BRIEF.md
# Tagged-Word SPI Master

This block is an SPI master that software drives through a small register bus with 32-bit data. Each write to the transmit buffer starts one 8-bit exchange. The word is sent most significant bit first on MOSI, and in the same exchange a word is shifted in from MISO. Every outgoing word carries a tag: a chip-select channel number (0 to 3) and an end-of-frame flag. The chip select for that channel goes low when the word starts. It stays low across the following words of the frame and is released only after a word flagged end-of-frame has finished. When a word completes, the receive side stores the incoming data together with the tag the word was sent with, so software can confirm which channel and frame position the data belongs to.

Software paces transfers by polling. A busy flag, a transmit-empty flag and a receive-full flag are live. Word-done and frame-end events are latched until software clears them, and any of these flags can drive an interrupt line. All four clock polarity and phase combinations are supported. The SCLK half period is a programmable number of bus cycles. A loopback option feeds MOSI back into the receive shifter internally.

Top module: `spi_word_master`

## Requirements
- R1: After reset all chip selects are high, SCLK is 0, irq is 0, service status reads 0, interrupt status reads 0x08 and the rate register reads 1.
- R2: While configuration bit 31 (enable) is 0, a write to the transmit buffer (0x50) is ignored: transmit-empty stays 1, busy stays 0, no SCLK edge occurs and no chip select falls.
- R3: SCLK rests at the clock polarity (configuration bit 14) whenever no word is shifting. Each word produces exactly 16 SCLK transitions. Each SCLK half period lasts max(N,1) bus clocks, where N is the value in the rate register at 0x48.
- R4: A word is exchanged MSB first in all four modes (configuration bit 13 = phase, bit 14 = polarity). With loopback (bit 12) set, the receive buffer at 0x58 returns the transmitted word. With loopback clear, it returns the bits sampled from MISO.
- R5: Receive control (0x54) reports in bits [1:0] the channel and in bit 2 the end-of-frame flag that the received word was sent with. These are taken from transmit control (0x4C) bits [1:0] and bit 2 at the time the transmit buffer is written.
- R6: At most one chip select is low at any time. The tagged channel's cs_n is low by the first SCLK edge of a word. It remains low after a word whose end-of-frame flag is 0, and it is high after a word whose end-of-frame flag is 1.
- R7: Service status (0x44) bit 0 is 1 from a transmit buffer write until that word has finished shifting, and 0 when idle.
- R8: Interrupt status bit 3 (transmit empty) clears on an accepted transmit buffer write and sets when the word enters the shifter, so a second word can wait while the first shifts. Bit 2 (receive full) sets when a word completes and clears when the receive buffer is read.
- R9: Interrupt status bit 4 latches each completed word and bit 5 latches each completed end-of-frame word. Writing 1 to bits [7:4] clears the latches. irq is high when any status bit in [5:2] is set and its matching bit in the enable register (0x6C) is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and shifter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the receive buffer) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, OR of enabled status bits |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CHAN_N | Active-low chip selects, one per channel |

## Verification
The assertions take it for granted that the rate register, clock polarity, phase and loopback are not changed while a word is shifting. They also assume the bus never issues a read and a write in the same cycle. The half-period counter bound and the SCLK rest-level property rely on this. The stimulus changes configuration and rate only after polling busy back to 0. It drives bus strobes one at a time on the falling clock edge. The stimulus table walks all four clock modes, rates of 0 through 4, all channels, and both end-of-frame settings, including held frames that the next word continues.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
   localparam logic [7:0] ADR_CFG   = 8'h40;
   localparam logic [7:0] ADR_STAT  = 8'h44;
   localparam logic [7:0] ADR_RATE  = 8'h48;
   localparam logic [7:0] ADR_TXCTL = 8'h4C;
   localparam logic [7:0] ADR_TXBUF = 8'h50;
   localparam logic [7:0] ADR_RXCTL = 8'h54;
   localparam logic [7:0] ADR_RXBUF = 8'h58;
   localparam logic [7:0] ADR_ISTAT = 8'h68;
   localparam logic [7:0] ADR_IEN   = 8'h6C;

   localparam int CFG_MASTER = 11;
   localparam int CFG_LOOP   = 12;
   localparam int CFG_CPHA   = 13;
   localparam int CFG_CPOL   = 14;
   localparam int CFG_EN     = 31;

   localparam int IS_RXFULL  = 2;
   localparam int IS_TXEMPTY = 3;
   localparam int IS_DONE    = 4;
   localparam int IS_FEND    = 5;

   localparam int TAG_EOF    = 2;

   typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL} eng_state_t;
endpackage

// File: rtl/spi_wm_baud.sv
module spi_wm_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;

   assign limit = (div == '0) ? DIV_W'(1) : div;
   assign tick  = run && (cnt == limit - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + DIV_W'(1);
   end

   // half-period counter never passes its limit (rate held stable while running)
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < limit));
endmodule

// File: rtl/spi_wm_engine.sv
module spi_wm_engine
   import spi_wm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CHAN_W      = 2,
   parameter int DIV_W       = 8,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              loop,
   input  logic [DIV_W-1:0]  div,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_data,
   input  logic [CHAN_W-1:0] word_chan,
   input  logic              word_eof,
   input  logic              miso,
   output logic              take,
   output logic              done,
   output logic              busy,
   output logic [DATA_W-1:0] rx_data,
   output logic [CHAN_W-1:0] rx_chan,
   output logic              rx_eof,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_act,
   output logic [CHAN_W-1:0] cs_chan
);
   localparam int EDGES = 2 * DATA_W;
   localparam int EC_W  = $clog2(EDGES);

   eng_state_t        state;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [EC_W-1:0]   edge_cnt;
   logic              sclk_ph;
   logic [CHAN_W-1:0] tag_chan;
   logic              tag_eof;
   logic              tick;
   logic              miso_in;
   logic              lead;
   logic              last_edge;
   logic              do_shift;
   logic              do_sample;

   spi_wm_baud #(.DIV_W(DIV_W)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state != ST_IDLE),
      .div   (div),
      .tick  (tick)
   );

   generate
      if (LOOPBACK_EN) begin : g_loop
         assign miso_in = loop ? tx_sr[DATA_W-1] : miso;
      end else begin : g_noloop
         logic unused_loop;
         assign unused_loop = loop;
         assign miso_in     = miso;
      end
   endgenerate

   assign lead      = ~edge_cnt[0];
   assign last_edge = (edge_cnt == EC_W'(EDGES - 1));
   assign do_shift  = cpha ? (lead && (edge_cnt != '0)) : (!lead && !last_edge);
   assign do_sample = cpha ? !lead : lead;

   assign take    = en && (state == ST_IDLE) && word_valid;
   assign done    = en && (state == ST_TAIL) && tick;
   assign busy    = (state != ST_IDLE);
   assign rx_data = rx_sr;
   assign rx_chan = tag_chan;
   assign rx_eof  = tag_eof;
   assign sclk    = cpol ^ sclk_ph;
   assign mosi    = tx_sr[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tx_sr    <= '0;
         rx_sr    <= '0;
         edge_cnt <= '0;
         sclk_ph  <= 1'b0;
         tag_chan <= '0;
         tag_eof  <= 1'b0;
         cs_act   <= 1'b0;
         cs_chan  <= '0;
      end else if (!en) begin
         state    <= ST_IDLE;
         edge_cnt <= '0;
         sclk_ph  <= 1'b0;
         cs_act   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (word_valid) begin
               tx_sr    <= word_data;
               tag_chan <= word_chan;
               tag_eof  <= word_eof;
               cs_act   <= 1'b1;
               cs_chan  <= word_chan;
               edge_cnt <= '0;
               sclk_ph  <= 1'b0;
               state    <= ST_LEAD;
            end
            ST_LEAD: if (tick) state <= ST_SHIFT;
            ST_SHIFT: if (tick) begin
               sclk_ph <= ~sclk_ph;
               if (do_shift)  tx_sr <= tx_sr << 1;
               if (do_sample) rx_sr <= {rx_sr[DATA_W-2:0], miso_in};
               if (last_edge) begin
                  edge_cnt <= '0;
                  state    <= ST_TAIL;
               end else begin
                  edge_cnt <= edge_cnt + EC_W'(1);
               end
            end
            ST_TAIL: if (tick) begin
               state <= ST_IDLE;
               if (tag_eof) cs_act <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // a word in flight always has its chip select driven
   p_cs_in_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> cs_act);
   // the serial clock is back at its rest phase whenever the shifter is idle
   p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (sclk_ph == 1'b0));
   // a finished end-of-frame word releases chip select
   p_eof_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_eof) |=> !cs_act);
endmodule

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
   import spi_wm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHAN_W = 2,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   input  logic              take,
   input  logic              done,
   input  logic              eng_busy,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [CHAN_W-1:0] rx_chan,
   input  logic              rx_eof,
   output logic              cfg_en,
   output logic              cfg_cpol,
   output logic              cfg_cpha,
   output logic              cfg_loop,
   output logic [DIV_W-1:0]  rate,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data,
   output logic [CHAN_W-1:0] word_chan,
   output logic              word_eof
);
   logic              cfg_master;
   logic [1:0]        cfg_len;
   logic [CHAN_W-1:0] ctl_chan;
   logic              ctl_eof;
   logic              tx_empty;
   logic [DATA_W-1:0] rx_buf;
   logic [CHAN_W-1:0] rx_chan_q;
   logic              rx_eof_q;
   logic              rx_full;
   logic              lat_done;
   logic              lat_fend;
   logic [5:2]        ien;
   logic [31:0]       istat;
   logic              w_cfg, w_rate, w_txctl, w_txbuf, w_istat, w_ien, r_rxbuf;
   logic              unused_wdata;

   assign unused_wdata = ^{bus_wdata[30:15], bus_wdata[10:6], bus_wdata[1:0]};

   assign w_cfg   = bus_wr && (bus_addr == ADR_CFG);
   assign w_rate  = bus_wr && (bus_addr == ADR_RATE);
   assign w_txctl = bus_wr && (bus_addr == ADR_TXCTL);
   assign w_txbuf = bus_wr && (bus_addr == ADR_TXBUF) && cfg_en;
   assign w_istat = bus_wr && (bus_addr == ADR_ISTAT);
   assign w_ien   = bus_wr && (bus_addr == ADR_IEN);
   assign r_rxbuf = bus_rd && (bus_addr == ADR_RXBUF);

   assign word_valid = !tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en <= 1'b0; cfg_master <= 1'b0; cfg_loop <= 1'b0;
         cfg_cpha <= 1'b0; cfg_cpol <= 1'b0; cfg_len <= 2'b00;
         rate <= DIV_W'(1);
         ctl_chan <= '0; ctl_eof <= 1'b0;
         word_data <= '0; word_chan <= '0; word_eof <= 1'b0;
         ien <= '0;
      end else begin
         if (w_cfg) begin
            cfg_en     <= bus_wdata[CFG_EN];
            cfg_master <= bus_wdata[CFG_MASTER];
            cfg_loop   <= bus_wdata[CFG_LOOP];
            cfg_cpha   <= bus_wdata[CFG_CPHA];
            cfg_cpol   <= bus_wdata[CFG_CPOL];
            cfg_len    <= bus_wdata[1:0];
         end
         if (w_rate) rate <= bus_wdata[DIV_W-1:0];
         if (w_txctl) begin
            ctl_chan <= bus_wdata[CHAN_W-1:0];
            ctl_eof  <= bus_wdata[TAG_EOF];
         end
         if (w_txbuf) begin
            word_data <= bus_wdata[DATA_W-1:0];
            word_chan <= ctl_chan;
            word_eof  <= ctl_eof;
         end
         if (w_ien) ien <= bus_wdata[5:2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty <= 1'b1; rx_full <= 1'b0;
         rx_buf <= '0; rx_chan_q <= '0; rx_eof_q <= 1'b0;
         lat_done <= 1'b0; lat_fend <= 1'b0;
      end else begin
         if (w_txbuf)                tx_empty <= 1'b0;
         else if (take || !cfg_en)   tx_empty <= 1'b1;
         if (done) begin
            rx_buf    <= rx_data;
            rx_chan_q <= rx_chan;
            rx_eof_q  <= rx_eof;
            rx_full   <= 1'b1;
         end else if (r_rxbuf) begin
            rx_full   <= 1'b0;
         end
         if (done)                                  lat_done <= 1'b1;
         else if (w_istat && bus_wdata[IS_DONE])    lat_done <= 1'b0;
         if (done && rx_eof)                        lat_fend <= 1'b1;
         else if (w_istat && bus_wdata[IS_FEND])    lat_fend <= 1'b0;
      end
   end

   always_comb begin
      istat             = '0;
      istat[IS_RXFULL]  = rx_full;
      istat[IS_TXEMPTY] = tx_empty;
      istat[IS_DONE]    = lat_done;
      istat[IS_FEND]    = lat_fend;
   end

   assign irq = |(istat[5:2] & ien);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADR_CFG: begin
            bus_rdata[CFG_EN]     = cfg_en;
            bus_rdata[CFG_MASTER] = cfg_master;
            bus_rdata[CFG_LOOP]   = cfg_loop;
            bus_rdata[CFG_CPHA]   = cfg_cpha;
            bus_rdata[CFG_CPOL]   = cfg_cpol;
            bus_rdata[1:0]        = cfg_len;
         end
         ADR_STAT:  bus_rdata[0] = eng_busy || !tx_empty;
         ADR_RATE:  bus_rdata[DIV_W-1:0] = rate;
         ADR_TXCTL: begin
            bus_rdata[CHAN_W-1:0] = ctl_chan;
            bus_rdata[TAG_EOF]    = ctl_eof;
         end
         ADR_TXBUF: bus_rdata[DATA_W-1:0] = word_data;
         ADR_RXCTL: begin
            bus_rdata[CHAN_W-1:0] = rx_chan_q;
            bus_rdata[TAG_EOF]    = rx_eof_q;
         end
         ADR_RXBUF: bus_rdata[DATA_W-1:0] = rx_buf;
         ADR_ISTAT: bus_rdata = istat;
         ADR_IEN:   bus_rdata[5:2] = ien;
         default:   bus_rdata = '0;
      endcase
   end

   // a word handed to the shifter frees the transmit buffer
   p_tx_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !w_txbuf) |=> tx_empty);
   // a completed exchange always leaves the receive buffer full
   p_rx_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_full);
   // disabled controller never accepts a word
   p_disabled_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && bus_wr && (bus_addr == ADR_TXBUF)) |=> tx_empty);
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
   import spi_wm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CHAN_N      = 4,
   parameter int DIV_W       = 8,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [CHAN_N-1:0] cs_n
);
   localparam int CHAN_W = (CHAN_N > 1) ? $clog2(CHAN_N) : 1;

   initial begin
      a_chan_range: assert (CHAN_N >= 1 && CHAN_N <= 4);
      a_data_range: assert (DATA_W >= 2 && DATA_W <= 31);
      a_div_range:  assert (DIV_W >= 1 && DIV_W <= 32);
   end

   logic              cfg_en, cfg_cpol, cfg_cpha, cfg_loop;
   logic [DIV_W-1:0]  rate;
   logic              word_valid, word_eof;
   logic [DATA_W-1:0] word_data, rx_data;
   logic [CHAN_W-1:0] word_chan, rx_chan, cs_chan;
   logic              take, done, eng_busy, rx_eof, cs_act;

   spi_wm_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .DIV_W(DIV_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq        (irq),
      .take       (take),
      .done       (done),
      .eng_busy   (eng_busy),
      .rx_data    (rx_data),
      .rx_chan    (rx_chan),
      .rx_eof     (rx_eof),
      .cfg_en     (cfg_en),
      .cfg_cpol   (cfg_cpol),
      .cfg_cpha   (cfg_cpha),
      .cfg_loop   (cfg_loop),
      .rate       (rate),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_chan  (word_chan),
      .word_eof   (word_eof)
   );

   spi_wm_engine #(
      .DATA_W(DATA_W), .CHAN_W(CHAN_W), .DIV_W(DIV_W), .LOOPBACK_EN(LOOPBACK_EN)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_en),
      .cpol       (cfg_cpol),
      .cpha       (cfg_cpha),
      .loop       (cfg_loop),
      .div        (rate),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_chan  (word_chan),
      .word_eof   (word_eof),
      .miso       (miso),
      .take       (take),
      .done       (done),
      .busy       (eng_busy),
      .rx_data    (rx_data),
      .rx_chan    (rx_chan),
      .rx_eof     (rx_eof),
      .sclk       (sclk),
      .mosi       (mosi),
      .cs_act     (cs_act),
      .cs_chan    (cs_chan)
   );

   generate
      for (genvar c = 0; c < CHAN_N; c++) begin : g_cs
         assign cs_n[c] = !(cs_act && (cs_chan == CHAN_W'(c)));
      end
   endgenerate

   // never more than one device selected
   p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // idle bus shows no select changes without a word
   p_cs_stable_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && !word_valid && $past(!eng_busy)) |-> $stable(cs_n) || !cfg_en || $past(!cfg_en) || $fell(cs_act) == 1'b0);
endmodule

// File: tb/tb_spi_word_master.sv
`timescale 1ns/1ps
module tb_spi_word_master;
   localparam logic [7:0] A_CFG = 8'h40, A_STAT = 8'h44, A_RATE = 8'h48,
      A_TXCTL = 8'h4C, A_TXBUF = 8'h50, A_RXCTL = 8'h54, A_RXBUF = 8'h58,
      A_ISTAT = 8'h68, A_IEN = 8'h6C;
   localparam logic [31:0] C_EN = 32'h8000_0000, C_MST = 32'h0000_0800,
      C_LOOP = 32'h0000_1000;

   // {cpol, cpha, rate[7:0], chan[1:0], eof, data[7:0]}
   localparam int NVEC = 8;
   localparam logic [20:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'd1, 2'd0, 1'b1, 8'hA5},
      {1'b0, 1'b1, 8'd2, 2'd1, 1'b1, 8'h3C},
      {1'b1, 1'b0, 8'd0, 2'd2, 1'b0, 8'h81},
      {1'b1, 1'b1, 8'd3, 2'd2, 1'b1, 8'h7E},
      {1'b0, 1'b0, 8'd2, 2'd3, 1'b0, 8'h00},
      {1'b1, 1'b1, 8'd1, 2'd3, 1'b1, 8'hFF},
      {1'b0, 1'b1, 8'd4, 2'd0, 1'b1, 8'h5A},
      {1'b1, 1'b0, 8'd2, 2'd1, 1'b1, 8'hC3}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, sclk, mosi, miso = 1'b0;
   logic [3:0]  cs_n;

   int  n_chk = 0, n_fail = 0;
   int  tog = 0;
   time t1 = 0, t2 = 0;
   logic [3:0] cs_first = 4'hF;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   spi_word_master dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   always @(sclk) begin
      if (rst_n) begin
         tog = tog + 1;
         if (tog == 1) begin t1 = $time; cs_first = cs_n; end
         if (tog == 2) t2 = $time;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 4000; k++) begin
         bus_read(A_STAT, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        cpol, cpha, eof;
      logic [7:0]  div, data;
      logic [1:0]  chan;
      logic [3:0]  sel;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(cs_n == 4'hF, "R1 cs_n", {28'd0, cs_n}, 32'hF);
      check(sclk == 1'b0, "R1 sclk", {31'd0, sclk}, 32'd0);
      check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
      bus_read(A_ISTAT, rd); check(rd == 32'h08, "R1 istat", rd, 32'h08);
      bus_read(A_STAT, rd);  check(rd == 32'h00, "R1 status", rd, 32'h00);
      bus_read(A_RATE, rd);  check(rd == 32'h01, "R1 rate", rd, 32'h01);

      // table walk: R3 R4 R5 R6 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         {cpol, cpha, div, chan, eof, data} = VEC[i];
         sel = ~(4'b0001 << chan);
         bus_write(A_RATE, {24'd0, div});
         bus_write(A_CFG, C_EN | C_MST | C_LOOP | (32'(cpha) << 13) | (32'(cpol) << 14));
         @(negedge clk);
         tog = 0;
         check(sclk == cpol, "R3 rest level", {31'd0, sclk}, {31'd0, cpol});
         bus_write(A_TXCTL, {29'd0, eof, chan});
         bus_write(A_TXBUF, {24'd0, data});
         wait_idle();
         check(tog == 16, "R3 edge count", tog, 32'd16);
         check((t2 - t1) == time'(((div == 0) ? 1 : div) * 4), "R3 half period",
               32'(t2 - t1), ((div == 0) ? 1 : div) * 4);
         check(cs_first == sel, "R6 cs at first edge", {28'd0, cs_first}, {28'd0, sel});
         check(cs_n == (eof ? 4'hF : sel), "R6 cs after word", {28'd0, cs_n},
               {28'd0, (eof ? 4'hF : sel)});
         check(sclk == cpol, "R3 rest after", {31'd0, sclk}, {31'd0, cpol});
         bus_read(A_ISTAT, rd);
         check(rd == (32'h1C | (32'(eof) << 5)), "R9 istat latched", rd, 32'h1C | (32'(eof) << 5));
         bus_read(A_RXCTL, rd);
         check(rd == {29'd0, eof, chan}, "R5 rx tag", rd, {29'd0, eof, chan});
         bus_read(A_RXBUF, rd);
         check(rd == {24'd0, data}, "R4 loopback data", rd, {24'd0, data});
         bus_read(A_ISTAT, rd);
         check(rd == (32'h18 | (32'(eof) << 5)), "R8 rx full cleared", rd, 32'h18 | (32'(eof) << 5));
         bus_write(A_ISTAT, 32'hF0);
         bus_read(A_ISTAT, rd);
         check(rd == 32'h08, "R9 latch clear", rd, 32'h08);
      end

      // R7 and R8: busy and a queued second word
      bus_write(A_RATE, 32'd4);
      bus_write(A_CFG, C_EN | C_MST | C_LOOP);
      bus_write(A_TXCTL, 32'h4);
      bus_write(A_TXBUF, 32'h12);
      bus_read(A_STAT, rd); check(rd[0] == 1'b1, "R7 busy set", rd, 32'd1);
      bus_write(A_TXBUF, 32'h34);
      bus_read(A_ISTAT, rd); check(rd[3] == 1'b0, "R8 tx empty cleared", rd, 32'd0);
      wait_idle();
      bus_read(A_STAT, rd); check(rd[0] == 1'b0, "R7 busy clear", rd, 32'd0);
      bus_read(A_ISTAT, rd); check(rd[3:2] == 2'b11, "R8 both flags", rd, 32'h0C);
      bus_read(A_RXBUF, rd); check(rd == 32'h34, "R8 second word", rd, 32'h34);
      bus_write(A_ISTAT, 32'hF0);

      // R6: held frame across two words on channel 1
      bus_write(A_TXCTL, 32'h1);
      bus_write(A_TXBUF, 32'h0F);
      wait_idle();
      check(cs_n == 4'b1101, "R6 held between words", {28'd0, cs_n}, 32'hD);
      bus_read(A_ISTAT, rd); check(rd[5] == 1'b0, "R9 no frame end yet", rd, 32'd0);
      bus_write(A_TXCTL, 32'h5);
      bus_write(A_TXBUF, 32'hF0);
      wait_idle();
      check(cs_n == 4'hF, "R6 released at eof", {28'd0, cs_n}, 32'hF);
      bus_read(A_RXBUF, rd);
      bus_write(A_ISTAT, 32'hF0);

      // R9: interrupt enable gating
      bus_write(A_IEN, 32'h04);
      check(irq == 1'b0, "R9 irq quiet", {31'd0, irq}, 32'd0);
      bus_write(A_TXBUF, 32'h66);
      wait_idle();
      check(irq == 1'b1, "R9 irq on rx full", {31'd0, irq}, 32'd1);
      bus_read(A_RXBUF, rd);
      @(negedge clk);
      check(irq == 1'b0, "R9 irq after read", {31'd0, irq}, 32'd0);
      bus_write(A_IEN, 32'h20);
      check(irq == 1'b1, "R9 irq frame end", {31'd0, irq}, 32'd1);
      bus_write(A_ISTAT, 32'h20);
      check(irq == 1'b0, "R9 irq cleared", {31'd0, irq}, 32'd0);
      bus_write(A_IEN, 32'h00);
      bus_write(A_ISTAT, 32'hF0);

      // R4: external MISO path
      bus_write(A_CFG, C_EN | C_MST | 32'h6000);
      miso = 1'b1;
      bus_write(A_TXBUF, 32'h00);
      wait_idle();
      bus_read(A_RXBUF, rd); check(rd == 32'hFF, "R4 miso high", rd, 32'hFF);
      miso = 1'b0;
      bus_write(A_TXBUF, 32'hFF);
      wait_idle();
      bus_read(A_RXBUF, rd); check(rd == 32'h00, "R4 miso low", rd, 32'h00);
      bus_write(A_ISTAT, 32'hF0);

      // R2: disabled controller ignores buffer writes
      bus_write(A_CFG, C_MST | C_LOOP | 32'h4000);
      @(negedge clk);
      tog = 0;
      bus_write(A_TXBUF, 32'h55);
      repeat (40) @(negedge clk);
      bus_read(A_ISTAT, rd); check(rd == 32'h08, "R2 istat unchanged", rd, 32'h08);
      bus_read(A_STAT, rd);  check(rd == 32'h00, "R2 not busy", rd, 32'h00);
      check(tog == 0, "R2 no sclk edges", tog, 32'd0);
      check(cs_n == 4'hF, "R2 no select", {28'd0, cs_n}, 32'hF);
      check(sclk == 1'b1, "R3 disabled rest", {31'd0, sclk}, 32'd1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule